// File: doc/BRIEF.md
# Interrupt Acknowledge Arbitration Unit

This unit decides which interrupt source answers an interrupt acknowledge cycle. A configurable number of internal modules each hold a 4-bit arbitration value. One extra slot, the system slot, speaks for two sources inside the system integration logic: the periodic timer and the external interrupt pins. Each source presents the interrupt level it is requesting, where 0 means it is not requesting.

When an acknowledge strobe arrives for level L, every source requesting exactly level L contends. The unit registers the outcome on the next clock edge and holds it until the bus cycle is reported done. The outcome is one of three kinds. A normal grant names the winner and, when the winner is the external pins, flags that the cycle must go out to the external bus. A spurious outcome arises when the winner's arbitration value is zero. A bus-error outcome arises when nothing contends.

Arbitration values are loaded through a simple write port. Equal nonzero values among contenders are a configuration fault: the unit sets a sticky flag and still resolves the contest deterministically.

Top module: `iaa_arbiter`

## Requirements
- R1: At an acknowledge of level L, only sources whose request level equals L contend, and the contender with the numerically greatest 4-bit arbitration value wins. Module k reports winner id k. The periodic timer reports id NMOD and the external pins report id NMOD+1.
- R2: After reset the system slot's arbitration value is 4'b1111 and every module's value is 4'b0000.
- R3: If the winning contender's arbitration value is 0, `spurious` is 1, `win_id` names that contender and `fwd_ext` is 0.
- R4: If no source contends, `bus_err` is 1, `win_id` is 0, and `spurious` and `fwd_ext` are 0.
- R5: `fwd_ext` is 1 only when the external pins win with a nonzero arbitration value.
- R6: Within the system slot, a timer request at level L outranks an external-pin request at level L. A timer level of 0 never contends.
- R7: If two or more contenders share the winning nonzero value, `cfg_err` rises and stays 1 until reset, and the lowest-indexed of them wins. For this rule the system slot has index NMOD.
- R8: Arbitration runs even with one contender: a lone contender with value 0 yields a spurious outcome, not a grant.
- R9: The outcome appears with `res_valid`=1 after the clock edge that samples `ack_stb`. It is held unchanged until an edge that samples `cyc_done` with `ack_stb` low, and then it clears to all zeros. `ack_stb` takes precedence over `cyc_done`.
- R10: Arbitration uses the values held before the edge. A write (`cfg_we`, `cfg_sel`, `cfg_val`; `cfg_sel`=NMOD selects the system slot) in the same cycle as `ack_stb` affects only later acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_lvl | input | NMOD*LVLW | Request level of each module, module k in bits [k*LVLW +: LVLW] |
| tmr_lvl | input | LVLW | Periodic timer request level, 0 = idle |
| ext_lvl | input | LVLW | External pin request level, 0 = idle |
| ack_stb | input | 1 | Acknowledge strobe, one cycle |
| ack_lvl | input | LVLW | Level being acknowledged |
| cyc_done | input | 1 | Acknowledge cycle finished |
| cfg_we | input | 1 | Arbitration value write enable |
| cfg_sel | input | SELW | Slot written (NMOD = system slot) |
| cfg_val | input | ARBW | Arbitration value written |
| res_valid | output | 1 | Outcome held |
| win_id | output | IDW | Winner identifier |
| fwd_ext | output | 1 | Forward cycle to external bus |
| spurious | output | 1 | Spurious interrupt outcome |
| bus_err | output | 1 | No contender, terminate with bus error |
| cfg_err | output | 1 | Sticky equal-value fault |

## Verification
Two things can land on the same edge: a write to an arbitration value and the acknowledge strobe that reads it. The bench triggers this by rewriting the system slot from 15 to 2 in the very cycle of an acknowledge in which the external pins face a module valued 5. It expects the external pins to win with the old value, and the module to win on the following acknowledge. A second collision, `ack_stb` together with `cyc_done`, is judged by requiring that the new outcome replaces the held one rather than clearing it.

// File: rtl/iaa_pkg.sv
package iaa_pkg;
   typedef enum logic [1:0] {
      OC_NONE  = 2'd0,
      OC_GRANT = 2'd1,
      OC_SPUR  = 2'd2,
      OC_BERR  = 2'd3
   } outcome_t;
endpackage

// File: rtl/iaa_arbregs.sv
module iaa_arbregs #(
   parameter int NMOD = 6,
   parameter int ARBW = 4,
   localparam int NS   = NMOD + 1,
   localparam int SELW = $clog2(NS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [SELW-1:0]      sel,
   input  logic [ARBW-1:0]      val,
   output logic [NS*ARBW-1:0]   arb_flat
);
   initial begin
      if (ARBW < 1) $error("ARBW must be at least 1");
   end

   for (genvar s = 0; s < NS; s++) begin : g_slot
      localparam logic [ARBW-1:0] RST_V = (s == NMOD) ? {ARBW{1'b1}} : '0;
      logic [ARBW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= RST_V;
         else if (we && sel == SELW'(s))      q <= val;
      end
      assign arb_flat[s*ARBW +: ARBW] = q;
   end
endmodule

// File: rtl/iaa_contend.sv
module iaa_contend
   import iaa_pkg::*;
#(
   parameter int NMOD = 6,
   parameter int ARBW = 4,
   parameter int LVLW = 3,
   localparam int NS  = NMOD + 1,
   localparam int IDW = $clog2(NMOD + 2)
) (
   input  logic [NS*ARBW-1:0]   arb_flat,
   input  logic [NMOD*LVLW-1:0] mod_lvl,
   input  logic [LVLW-1:0]      tmr_lvl,
   input  logic [LVLW-1:0]      ext_lvl,
   input  logic [LVLW-1:0]      ack_lvl,
   output logic [IDW-1:0]       win_id,
   output outcome_t             outcome,
   output logic                 fwd,
   output logic                 tie
);
   logic [NS-1:0] cont;
   logic          tmr_hit, ext_hit;

   assign tmr_hit = (tmr_lvl != '0) && (tmr_lvl == ack_lvl);
   assign ext_hit = (ext_lvl != '0) && (ext_lvl == ack_lvl);

   for (genvar m = 0; m < NMOD; m++) begin : g_cont
      logic [LVLW-1:0] lv;
      assign lv      = mod_lvl[m*LVLW +: LVLW];
      assign cont[m] = (lv != '0) && (lv == ack_lvl);
   end
   assign cont[NMOD] = tmr_hit || ext_hit;

   logic            found;
   logic [ARBW-1:0] best;
   int              bidx;
   int              nbest;

   always_comb begin
      found = 1'b0;
      best  = '0;
      bidx  = 0;
      nbest = 0;
      for (int s = 0; s < NS; s++) begin
         if (cont[s] && (!found || arb_flat[s*ARBW +: ARBW] > best)) begin
            found = 1'b1;
            best  = arb_flat[s*ARBW +: ARBW];
            bidx  = s;
         end
      end
      for (int s = 0; s < NS; s++) begin
         if (cont[s] && arb_flat[s*ARBW +: ARBW] == best) nbest = nbest + 1;
      end
   end

   always_comb begin
      win_id  = '0;
      outcome = OC_BERR;
      fwd     = 1'b0;
      tie     = 1'b0;
      if (found) begin
         if (bidx < NMOD)   win_id = IDW'(bidx);
         else if (tmr_hit)  win_id = IDW'(NMOD);
         else               win_id = IDW'(NMOD + 1);
         outcome = (best == '0) ? OC_SPUR : OC_GRANT;
         fwd     = (best != '0) && (bidx == NMOD) && !tmr_hit;
         tie     = (best != '0) && (nbest > 1);
      end
   end
endmodule

// File: rtl/iaa_arbiter.sv
module iaa_arbiter
   import iaa_pkg::*;
#(
   parameter int NMOD = 6,
   parameter int ARBW = 4,
   parameter int LVLW = 3,
   localparam int NS   = NMOD + 1,
   localparam int SELW = $clog2(NS),
   localparam int IDW  = $clog2(NMOD + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NMOD*LVLW-1:0] mod_lvl,
   input  logic [LVLW-1:0]      tmr_lvl,
   input  logic [LVLW-1:0]      ext_lvl,
   input  logic                 ack_stb,
   input  logic [LVLW-1:0]      ack_lvl,
   input  logic                 cyc_done,
   input  logic                 cfg_we,
   input  logic [SELW-1:0]      cfg_sel,
   input  logic [ARBW-1:0]      cfg_val,
   output logic                 res_valid,
   output logic [IDW-1:0]       win_id,
   output logic                 fwd_ext,
   output logic                 spurious,
   output logic                 bus_err,
   output logic                 cfg_err
);
   initial begin
      if (NMOD < 1) $error("NMOD must be at least 1");
      if (LVLW < 1) $error("LVLW must be at least 1");
   end

   logic [NS*ARBW-1:0] arb_flat;
   logic [IDW-1:0]     c_id;
   outcome_t           c_oc;
   logic               c_fwd, c_tie;

   iaa_arbregs #(.NMOD(NMOD), .ARBW(ARBW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .val(cfg_val),
      .arb_flat(arb_flat)
   );

   iaa_contend #(.NMOD(NMOD), .ARBW(ARBW), .LVLW(LVLW)) u_cont (
      .arb_flat(arb_flat), .mod_lvl(mod_lvl), .tmr_lvl(tmr_lvl),
      .ext_lvl(ext_lvl), .ack_lvl(ack_lvl), .win_id(c_id), .outcome(c_oc),
      .fwd(c_fwd), .tie(c_tie)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         win_id    <= '0;
         fwd_ext   <= 1'b0;
         spurious  <= 1'b0;
         bus_err   <= 1'b0;
         cfg_err   <= 1'b0;
      end else begin
         if (ack_stb) begin
            res_valid <= 1'b1;
            win_id    <= c_id;
            fwd_ext   <= c_fwd;
            spurious  <= (c_oc == OC_SPUR);
            bus_err   <= (c_oc == OC_BERR);
            if (c_tie) cfg_err <= 1'b1;
         end else if (cyc_done) begin
            res_valid <= 1'b0;
            win_id    <= '0;
            fwd_ext   <= 1'b0;
            spurious  <= 1'b0;
            bus_err   <= 1'b0;
         end
      end
   end

   AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({spurious, bus_err, fwd_ext}) <= 1); // R3
   AST_BERR_ID: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (win_id == '0) && res_valid); // R4
   AST_FWD_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_ext |-> (win_id == IDW'(NMOD + 1)) && res_valid); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err); // R7
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !ack_stb && !cyc_done |=> res_valid && $stable(win_id)); // R9
   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done && !ack_stb |=> !res_valid && !spurious && !bus_err); // R9
endmodule

// File: tb/sim_iaa_arbiter.sv
module sim_iaa_arbiter;
   localparam int NMOD = 3;
   localparam int LVLW = 3;
   localparam int IDW  = $clog2(NMOD + 2);
   localparam int SELW = $clog2(NMOD + 1);

   logic clk = 0, rst_n = 0;
   logic [NMOD*LVLW-1:0] mod_lvl = '0;
   logic [LVLW-1:0] tmr_lvl = '0, ext_lvl = '0, ack_lvl = '0;
   logic ack_stb = 0, cyc_done = 0, cfg_we = 0;
   logic [SELW-1:0] cfg_sel = '0;
   logic [3:0] cfg_val = '0;
   logic res_valid, fwd_ext, spurious, bus_err, cfg_err;
   logic [IDW-1:0] win_id;

   iaa_arbiter #(.NMOD(NMOD), .ARBW(4), .LVLW(LVLW)) u0 (
      .clk(clk), .rst_n(rst_n), .mod_lvl(mod_lvl), .tmr_lvl(tmr_lvl),
      .ext_lvl(ext_lvl), .ack_stb(ack_stb), .ack_lvl(ack_lvl),
      .cyc_done(cyc_done), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_val(cfg_val), .res_valid(res_valid), .win_id(win_id),
      .fwd_ext(fwd_ext), .spurious(spurious), .bus_err(bus_err),
      .cfg_err(cfg_err)
   );

   always #2.5 clk = ~clk;

   int checks = 0, errors = 0;
   int arb [NMOD+1];
   int ml [NMOD];
   int exp_err = 0;
   bit done = 0;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply_lvls(int t, int e);
      for (int m = 0; m < NMOD; m++) mod_lvl[m*LVLW +: LVLW] = LVLW'(ml[m]);
      tmr_lvl = LVLW'(t);
      ext_lvl = LVLW'(e);
   endtask

   task automatic wr(int s, int v);
      @(negedge clk);
      cfg_we = 1; cfg_sel = SELW'(s); cfg_val = 4'(v);
      @(negedge clk);
      cfg_we = 0;
      arb[s] = v;
   endtask

   // expected outcome from the requirements
   task automatic model(int L, int t, int e, output int id, output int sp,
                        output int be, output int fx, output int tie);
      int best, bi, cnt;
      bit c;
      best = -1; bi = 0; cnt = 0;
      for (int s = 0; s <= NMOD; s++) begin
         c = (s < NMOD) ? (ml[s] == L) : (t == L || e == L);
         if (c && arb[s] > best) begin best = arb[s]; bi = s; end
      end
      for (int s = 0; s <= NMOD; s++) begin
         c = (s < NMOD) ? (ml[s] == L) : (t == L || e == L);
         if (c && arb[s] == best) cnt++;
      end
      id = 0; sp = 0; be = 0; fx = 0; tie = 0;
      if (best < 0) be = 1;
      else begin
         id  = (bi < NMOD) ? bi : ((t == L) ? NMOD : NMOD + 1);
         sp  = (best == 0);
         fx  = (id == NMOD + 1) && best != 0;
         tie = (best != 0) && cnt > 1;
      end
   endtask

   task automatic ack_check(string req, int L, int t, int e);
      int id, sp, be, fx, tie;
      model(L, t, e, id, sp, be, fx, tie);
      if (tie) exp_err = 1;
      @(negedge clk);
      ack_stb = 1; ack_lvl = LVLW'(L);
      @(posedge clk); #1;
      chk({req, " valid"}, res_valid, 1);
      chk({req, " win_id"}, win_id, id);
      chk({req, " spurious"}, spurious, sp);
      chk({req, " bus_err"}, bus_err, be);
      chk({req, " fwd_ext"}, fwd_ext, fx);
      chk({req, " R7 cfg_err"}, cfg_err, exp_err);
      @(negedge clk);
      ack_stb = 0; cyc_done = 1;
      @(posedge clk); #1;
      chk({req, " R9 cleared"}, res_valid, 0);
      @(negedge clk);
      cyc_done = 0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      int t, e, L;
      arb[NMOD] = 15;
      for (int m = 0; m < NMOD; m++) begin arb[m] = 0; ml[m] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(posedge clk); #1;
      chk("R9 reset valid", res_valid, 0);
      chk("R9 reset win_id", win_id, 0);
      chk("R7 reset cfg_err", cfg_err, 0);

      // R2: reset values observed through contests
      ml[0] = 0; apply_lvls(0, 3);
      ack_check("R2 R5 ext alone", 3, 0, 3);
      ml[0] = 3; apply_lvls(0, 0);
      ack_check("R2 R8 lone zero module", 3, 0, 0);
      apply_lvls(0, 3);
      ack_check("R2 R1 ext beats zero", 3, 0, 3);
      // R4 nobody at level
      ack_check("R4 no contender", 5, 0, 3);
      // R6 timer over pins
      ml[0] = 0; apply_lvls(2, 2);
      ack_check("R6 timer first", 2, 2, 2);
      apply_lvls(0, 2);
      ack_check("R6 timer idle", 2, 0, 2);

      // R10: write colliding with acknowledge
      wr(0, 5);
      ml[0] = 4; apply_lvls(0, 4);
      @(negedge clk);
      ack_stb = 1; ack_lvl = 3'd4;
      cfg_we = 1; cfg_sel = SELW'(NMOD); cfg_val = 4'd2;
      @(posedge clk); #1;
      chk("R10 old value wins", win_id, NMOD + 1);
      chk("R10 fwd", fwd_ext, 1);
      @(negedge clk);
      ack_stb = 0; cfg_we = 0; arb[NMOD] = 2;
      // R9 hold
      repeat (3) @(posedge clk); #1;
      chk("R9 held valid", res_valid, 1);
      chk("R9 held id", win_id, NMOD + 1);
      // R9 ack precedence over done
      @(negedge clk);
      ack_stb = 1; cyc_done = 1;
      @(posedge clk); #1;
      chk("R9 R10 new value", win_id, 0);
      chk("R9 ack over done", res_valid, 1);
      @(negedge clk);
      ack_stb = 0;
      @(posedge clk); #1;
      chk("R9 done clears", res_valid, 0);
      @(negedge clk);
      cyc_done = 0;

      // sweep
      seed = 7;
      for (int k = 0; k < 400; k++) begin
         for (int s = 0; s <= NMOD; s++) begin
            seed = seed * 1103515245 + 12345;
            wr(s, (k < 200) ? ((seed >>> 16) & 3) * 5 : (seed >>> 16) & 15);
         end
         for (int m = 0; m < NMOD; m++) begin
            seed = seed * 1103515245 + 12345;
            ml[m] = (seed >>> 16) & 3;
         end
         seed = seed * 1103515245 + 12345;
         t = (seed >>> 16) & 3;
         e = (seed >>> 20) & 3;
         L = ((seed >>> 24) % 3) + 1;
         if (L < 1) L = 1;
         apply_lvls(t, e);
         ack_check("R1 R3 R5 R7 sweep", L, t, e);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule